// File: doc/BRIEF.md
# SDRAM Bank Command Timing Sequencer

This block sits between a simple request front end and the command pins of a synchronous DRAM. A requester presents a bank, a row and a column with a read/write flag under a valid/ready handshake. The sequencer keeps the open or closed state and the open row of every bank. It issues precharge, activate and column commands in the order the request needs, and every command is held back until the minimum spacing since earlier commands has elapsed. All spacings are parameters counted in clocks, so the same block can be checked at other clock periods.

After reset the block closes all banks and then loads the mode register once. During normal running a refresh timer raises a refresh debt at a fixed interval. While that debt is owed, new requests stall. Any open banks are closed with a single all-bank precharge, and an auto refresh follows once every bank has closed. The command bus is registered. A column strobe and a write flag that leave in the same cycle tell the data path when a read or write command went out. Every transfer has a burst length of one, and write data travels in the cycle of the write command.

Top module: `sdram_cmd_seq`

## Requirements
- R1: The command sits on {cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n}, registered. The codes are: activate 0011, read 0101, write 0100, precharge 0010, auto refresh 0001, mode load 0000, and idle 1111 (chip select high). col_strobe is high exactly in the cycles that carry a read or write, and col_write is high only with a write.
- R2: While reset is held the bus is idle and col_strobe is low. The first command after reset is an all-bank precharge (cmd_addr bit 10 high). The second is a mode load carrying MODE_WORD on cmd_addr, at least T_RP clocks later. Banks are closed while the mode load is issued.
- R3: cmd_ba carries the request bank as a binary number 0 to 3. A precharge with cmd_addr bit 10 high closes all banks. With bit 10 low it closes only the bank on cmd_ba.
- R4: A read or write to a bank comes at least T_RCD clocks (default 2) after that bank's activate.
- R5: An activate comes at least T_RP clocks (2) after a precharge of the same bank, at least T_RC clocks (7) after the previous activate of the same bank, and at least T_RC clocks after an auto refresh.
- R6: A precharge of an open bank comes at least T_RAS clocks (5) after its activate and at least T_WR clocks (2) after its last write command.
- R7: Activates to any two banks are at least T_RRD clocks (2) apart, and an activate comes at least T_MRD clocks (1) after a mode load.
- R8: A request is accepted in a cycle where req_valid and req_ready are both high. Its read or write appears on the bus in the next cycle. A request to the open row of its bank needs no precharge or activate, and column commands may follow each other on consecutive clocks.
- R9: A request to a closed bank gets an activate of its row. A request to a bank open on another row gets a precharge of that bank first. No activate or single-bank precharge is issued except for the pending request.
- R10: On an activate, cmd_addr is the row. On a column command, column bits 9:0 go to cmd_addr 9:0, column bit 10 goes to cmd_addr 11, and cmd_addr 10 is low (no auto-precharge).
- R11: A refresh becomes owed every T_REFI clocks. Open banks are closed by one all-bank precharge, and the next command after that precharge is the auto refresh. Refresh is issued only with all banks closed for at least T_RP clocks. Successive refreshes sit T_REFI clocks apart, within a few clocks of closing delay.
- R12: req_ready stays low while a refresh is owed, so refresh takes priority over any new activate or column command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present; fields held until accepted |
| req_ready | output | 1 | Request accepted this cycle (column command issued) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bank | input | BANK_W | Target bank |
| req_row | input | ROW_W | Target row |
| req_col | input | COL_W | Target column |
| cmd_cs_n | output | 1 | Chip select, active low |
| cmd_ras_n | output | 1 | Row strobe level |
| cmd_cas_n | output | 1 | Column strobe level |
| cmd_we_n | output | 1 | Write enable level |
| cmd_ba | output | BANK_W | Bank address |
| cmd_addr | output | ROW_W | Row, column or mode address |
| col_strobe | output | 1 | A read or write is on the bus this cycle |
| col_write | output | 1 | The column command on the bus is a write |

## Verification
A wrong open flag or open row in a bank shows up within a clock of the next request to that bank. The sequencer would put a column command on the bus with no activate, or activate a bank that is already open, or precharge a bank on a row hit. The bench catches each of these by comparing the bus against its own bank model. A spacing counter that is off by even one clock shows up as a command placed one cycle too early. The bench measures every gap in whole cycles against the parameter it depends on. A refresh debt that is lost or cleared too soon changes the distance between refreshes by a full interval, or lets a command slip between the closing precharge and the refresh.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;
   // Command code as {cs_n, ras_n, cas_n, we_n}
   typedef logic [3:0] cmd_t;
   localparam cmd_t CMD_DESL  = 4'b1111;
   localparam cmd_t CMD_ACT   = 4'b0011;
   localparam cmd_t CMD_READ  = 4'b0101;
   localparam cmd_t CMD_WRITE = 4'b0100;
   localparam cmd_t CMD_PRE   = 4'b0010;
   localparam cmd_t CMD_REF   = 4'b0001;
   localparam cmd_t CMD_MRS   = 4'b0000;

   typedef enum logic [1:0] {PH_INIT_PRE, PH_INIT_MRS, PH_RUN} phase_t;

   function automatic int unsigned max2(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction
endpackage

// File: rtl/sdram_sat_cnt.sv
// Clocks elapsed since the last restart, saturating at all ones.
module sdram_sat_cnt #(
   parameter int unsigned W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         restart,
   output logic [W-1:0] value
);
   localparam logic [W-1:0] SAT = '1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              value <= SAT;
      else if (restart)        value <= W'(1);
      else if (value != SAT)   value <= value + W'(1);
   end
endmodule

// File: rtl/sdram_bank_track.sv
// One bank: open state, open row and its spacing windows.
module sdram_bank_track #(
   parameter int unsigned ROW_W = 13,
   parameter int unsigned CNT_W = 4,
   parameter int unsigned T_RCD = 2,
   parameter int unsigned T_RP  = 2,
   parameter int unsigned T_RAS = 5,
   parameter int unsigned T_RC  = 7,
   parameter int unsigned T_WR  = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             do_act,
   input  logic             do_pre,
   input  logic             do_col,
   input  logic             col_wr,
   input  logic [ROW_W-1:0] act_row,
   output logic             is_open,
   output logic [ROW_W-1:0] open_row,
   output logic             act_ok,
   output logic             col_ok,
   output logic             pre_ok
);
   logic [CNT_W-1:0] since_act, since_pre, since_wr;

   if ((1 << CNT_W) <= T_RC) begin : g_bad_cnt
      $error("CNT_W too narrow for T_RC");
   end

   sdram_sat_cnt #(.W(CNT_W)) i_act_cnt (.clk(clk), .rst_n(rst_n), .restart(do_act),          .value(since_act));
   sdram_sat_cnt #(.W(CNT_W)) i_pre_cnt (.clk(clk), .rst_n(rst_n), .restart(do_pre),          .value(since_pre));
   sdram_sat_cnt #(.W(CNT_W)) i_wr_cnt  (.clk(clk), .rst_n(rst_n), .restart(do_col && col_wr), .value(since_wr));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         is_open  <= 1'b0;
         open_row <= '0;
      end else if (do_act) begin
         is_open  <= 1'b1;
         open_row <= act_row;
      end else if (do_pre) begin
         is_open  <= 1'b0;
      end
   end

   assign act_ok = !is_open && (since_pre >= CNT_W'(T_RP)) && (since_act >= CNT_W'(T_RC));
   assign col_ok = is_open && (since_act >= CNT_W'(T_RCD));
   assign pre_ok = !is_open || ((since_act >= CNT_W'(T_RAS)) && (since_wr >= CNT_W'(T_WR)));

   AST_ACT_ON_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
      do_act |-> !is_open) else $error("activate on open bank");                              // R9
   AST_ACT_AFTER_PRE: assert property (@(posedge clk) disable iff (!rst_n)
      do_act |-> (since_pre >= CNT_W'(T_RP)) && (since_act >= CNT_W'(T_RC)));                 // R5
   AST_COL_AFTER_ACT: assert property (@(posedge clk) disable iff (!rst_n)
      do_col |-> is_open && (since_act >= CNT_W'(T_RCD)));                                    // R4
   AST_PRE_AFTER_RAS: assert property (@(posedge clk) disable iff (!rst_n)
      (do_pre && is_open) |-> (since_act >= CNT_W'(T_RAS)) && (since_wr >= CNT_W'(T_WR)));   // R6
endmodule

// File: rtl/sdram_refresh_timer.sv
// Raises a refresh debt every T_REFI clocks; cleared when the refresh goes out.
module sdram_refresh_timer #(
   parameter int unsigned T_REFI = 781
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ref_done,
   output logic owed
);
   localparam int unsigned RW = (T_REFI > 1) ? $clog2(T_REFI) : 1;
   logic [RW-1:0] cnt;
   logic          tick;

   if (T_REFI < 32) begin : g_bad_refi
      $error("T_REFI too short to close banks and refresh");
   end

   assign tick = (cnt == RW'(T_REFI - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         owed <= 1'b0;
      end else begin
         cnt  <= tick ? '0 : cnt + RW'(1);
         if (tick)          owed <= 1'b1;
         else if (ref_done) owed <= 1'b0;
      end
   end

   AST_REF_NOT_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
      tick |-> !owed) else $error("refresh debt not paid within one interval");   // R11
endmodule

// File: rtl/sdram_cmd_seq.sv
module sdram_cmd_seq
   import sdram_seq_pkg::*;
#(
   parameter int unsigned ROW_W     = 13,
   parameter int unsigned COL_W     = 11,
   parameter int unsigned BANK_W    = 2,
   parameter int unsigned T_RCD     = 2,
   parameter int unsigned T_RP      = 2,
   parameter int unsigned T_RAS     = 5,
   parameter int unsigned T_RC      = 7,
   parameter int unsigned T_RRD     = 2,
   parameter int unsigned T_WR      = 2,
   parameter int unsigned T_MRD     = 1,
   parameter int unsigned T_REFI    = 781,
   parameter int unsigned MODE_WORD = 'h030
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [BANK_W-1:0] req_bank,
   input  logic [ROW_W-1:0]  req_row,
   input  logic [COL_W-1:0]  req_col,
   output logic              cmd_cs_n,
   output logic              cmd_ras_n,
   output logic              cmd_cas_n,
   output logic              cmd_we_n,
   output logic [BANK_W-1:0] cmd_ba,
   output logic [ROW_W-1:0]  cmd_addr,
   output logic              col_strobe,
   output logic              col_write
);
   localparam int unsigned NUM_BANKS = 1 << BANK_W;
   localparam int unsigned MAX_T     = max2(max2(max2(T_RC, T_RAS), max2(T_RCD, T_RP)),
                                            max2(max2(T_RRD, T_WR), T_MRD));
   localparam int unsigned CNT_W     = $clog2(MAX_T + 1) + 1;

   if (ROW_W < 11)                        begin : g_bad_row  $error("address needs bit 10"); end
   if (COL_W > 10 && COL_W + 1 > ROW_W)   begin : g_bad_col  $error("column does not fit around bit 10"); end
   if (T_RC < T_RAS + T_RP)               begin : g_bad_rc   $error("T_RC below T_RAS + T_RP"); end

   function automatic logic [ROW_W-1:0] col_addr(input logic [COL_W-1:0] c);
      logic [ROW_W-1:0] a;
      a = '0;
      for (int i = 0; i < COL_W; i++) begin
         if (i < 10) a[i] = c[i];
         else        a[i + 1] = c[i];
      end
      return a;
   endfunction

   phase_t                 phase;
   logic [NUM_BANKS-1:0]   open_v, act_ok_v, col_ok_v, pre_ok_v, do_act_v, do_pre_v, do_col_v;
   logic [ROW_W-1:0]       open_row_v [NUM_BANKS];
   logic [CNT_W-1:0]       since_rrd, since_ref, since_mrs;
   logic                   ref_owed;
   logic                   iss_act, iss_pre_one, iss_pre_all, iss_col, iss_ref, iss_mrs, gap_ok;
   cmd_t                   nxt_cmd;
   logic [ROW_W-1:0]       nxt_addr;

   for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
      assign do_act_v[g] = iss_act && (req_bank == BANK_W'(g));
      assign do_pre_v[g] = iss_pre_all || (iss_pre_one && (req_bank == BANK_W'(g)));
      assign do_col_v[g] = iss_col && (req_bank == BANK_W'(g));
      sdram_bank_track #(.ROW_W(ROW_W), .CNT_W(CNT_W), .T_RCD(T_RCD), .T_RP(T_RP),
                         .T_RAS(T_RAS), .T_RC(T_RC), .T_WR(T_WR)) i_bank (
         .clk(clk), .rst_n(rst_n), .do_act(do_act_v[g]), .do_pre(do_pre_v[g]),
         .do_col(do_col_v[g]), .col_wr(req_write), .act_row(req_row),
         .is_open(open_v[g]), .open_row(open_row_v[g]),
         .act_ok(act_ok_v[g]), .col_ok(col_ok_v[g]), .pre_ok(pre_ok_v[g]));
   end

   sdram_sat_cnt #(.W(CNT_W)) i_rrd_cnt (.clk(clk), .rst_n(rst_n), .restart(iss_act), .value(since_rrd));
   sdram_sat_cnt #(.W(CNT_W)) i_ref_cnt (.clk(clk), .rst_n(rst_n), .restart(iss_ref), .value(since_ref));
   sdram_sat_cnt #(.W(CNT_W)) i_mrs_cnt (.clk(clk), .rst_n(rst_n), .restart(iss_mrs), .value(since_mrs));

   sdram_refresh_timer #(.T_REFI(T_REFI)) i_refresh (
      .clk(clk), .rst_n(rst_n), .ref_done(iss_ref), .owed(ref_owed));

   assign gap_ok = (since_rrd >= CNT_W'(T_RRD)) && (since_ref >= CNT_W'(T_RC)) &&
                   (since_mrs >= CNT_W'(T_MRD));

   // Arbitration: init steps, then refresh debt, then the pending request.
   always_comb begin
      iss_act = 1'b0; iss_pre_one = 1'b0; iss_pre_all = 1'b0;
      iss_col = 1'b0; iss_ref = 1'b0;     iss_mrs = 1'b0;
      req_ready = 1'b0;
      unique case (phase)
         PH_INIT_PRE: iss_pre_all = 1'b1;
         PH_INIT_MRS: iss_mrs = &act_ok_v;
         default: begin
            if (ref_owed) begin
               if (|open_v) iss_pre_all = &pre_ok_v;
               else         iss_ref     = &act_ok_v;
            end else if (req_valid) begin
               if (open_v[req_bank] && (open_row_v[req_bank] == req_row)) begin
                  iss_col   = col_ok_v[req_bank];
                  req_ready = col_ok_v[req_bank];
               end else if (open_v[req_bank]) begin
                  iss_pre_one = pre_ok_v[req_bank];
               end else begin
                  iss_act = act_ok_v[req_bank] && gap_ok;
               end
            end
         end
      endcase

      nxt_cmd  = CMD_DESL;
      nxt_addr = '0;
      if (iss_pre_all) begin
         nxt_cmd      = CMD_PRE;
         nxt_addr[10] = 1'b1;
      end else if (iss_pre_one) begin
         nxt_cmd  = CMD_PRE;
      end else if (iss_act) begin
         nxt_cmd  = CMD_ACT;
         nxt_addr = req_row;
      end else if (iss_col) begin
         nxt_cmd  = req_write ? CMD_WRITE : CMD_READ;
         nxt_addr = col_addr(req_col);
      end else if (iss_ref) begin
         nxt_cmd  = CMD_REF;
      end else if (iss_mrs) begin
         nxt_cmd  = CMD_MRS;
         nxt_addr = ROW_W'(MODE_WORD);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= PH_INIT_PRE;
         {cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n} <= CMD_DESL;
         cmd_ba     <= '0;
         cmd_addr   <= '0;
         col_strobe <= 1'b0;
         col_write  <= 1'b0;
      end else begin
         if (phase == PH_INIT_PRE)        phase <= PH_INIT_MRS;
         else if (iss_mrs)                phase <= PH_RUN;
         {cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n} <= nxt_cmd;
         cmd_ba     <= (iss_pre_one || iss_act || iss_col) ? req_bank : '0;
         cmd_addr   <= nxt_addr;
         col_strobe <= iss_col;
         col_write  <= iss_col && req_write;
      end
   end

   AST_RRD_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      iss_act |-> (since_rrd >= CNT_W'(T_RRD)) && (since_mrs >= CNT_W'(T_MRD)));     // R7
   AST_REF_ALL_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
      iss_ref |-> (open_v == '0));                                                   // R11
   AST_MRS_ALL_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
      iss_mrs |-> (open_v == '0));                                                   // R2
   AST_ACCEPT_COL: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> (col_strobe && !cmd_cs_n && cmd_ras_n && !cmd_cas_n)); // R8
   AST_OWED_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      ref_owed |-> !req_ready);                                                      // R12
endmodule

// File: tb/test_sdram_cmd_seq.sv
module test_sdram_cmd_seq;
   timeunit 1ns;
   timeprecision 100ps;
   import sdram_seq_pkg::*;

   localparam int ROW_W = 13, COL_W = 11, BANK_W = 2;
   localparam int T_RCD = 2, T_RP = 2, T_RAS = 5, T_RC = 7, T_RRD = 2, T_WR = 2, T_MRD = 1;
   localparam int T_REFI = 150, MODE = 'h032, SLACK = 20;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic              rst_n = 1'b0;
   logic              req_valid = 1'b0, req_write = 1'b0;
   logic [BANK_W-1:0] req_bank = '0;
   logic [ROW_W-1:0]  req_row = '0;
   logic [COL_W-1:0]  req_col = '0;
   logic              req_ready, cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n, col_strobe, col_write;
   logic [BANK_W-1:0] cmd_ba;
   logic [ROW_W-1:0]  cmd_addr;

   sdram_cmd_seq #(.ROW_W(ROW_W), .COL_W(COL_W), .BANK_W(BANK_W), .T_RCD(T_RCD), .T_RP(T_RP),
      .T_RAS(T_RAS), .T_RC(T_RC), .T_RRD(T_RRD), .T_WR(T_WR), .T_MRD(T_MRD),
      .T_REFI(T_REFI), .MODE_WORD(MODE)) i_sdram_cmd_seq (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
      .cmd_cs_n(cmd_cs_n), .cmd_ras_n(cmd_ras_n), .cmd_cas_n(cmd_cas_n), .cmd_we_n(cmd_we_n),
      .cmd_ba(cmd_ba), .cmd_addr(cmd_addr), .col_strobe(col_strobe), .col_write(col_write));

   int checks = 0, fails = 0, cyc = 0, n_ref = 0, init_st = 0;
   int l_act[4], l_pre[4], l_wr[4], m_row[4];
   bit m_open[4];
   int l_any_act = -1000, l_ref = -1000, l_ref_int = 0, l_mrs = -1000;
   bit exp_ref = 1'b0, acc_now = 1'b0, awr = 1'b0, pwr = 1'b0;
   int ab = 0, arow = 0, acol = 0, pb = 0, prow = 0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", req, cyc, act, exp);
      end
   endtask

   function automatic int exp_col_addr(input int c);
      return (c & 'h3FF) | ((c >> 10) << 11);
   endfunction

   always @(posedge clk) begin
      cyc     <= cyc + 1;
      acc_now <= rst_n && req_valid && req_ready;
      ab      <= int'(req_bank);
      arow    <= int'(req_row);
      acol    <= int'(req_col);
      awr     <= req_write;
   end

   // Bus monitor: every command is checked against the bank model.
   always @(negedge clk) begin
      cmd_t c;
      int   b, a;
      c = {cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n};
      b = int'(cmd_ba);
      a = int'(cmd_addr);
      if (!rst_n) begin
         chk(cmd_cs_n && !col_strobe, "R2 reset idle", int'(c), int'(CMD_DESL));
      end else if (c == CMD_DESL) begin
         if (col_strobe) chk(1'b0, "R1 strobe without column command", 1, 0);
         if (acc_now)    chk(1'b0, "R8 column missing after accept", int'(c), int'(CMD_READ));
         if (exp_ref && req_ready) chk(1'b0, "R12 ready while refresh owed", 1, 0);
      end else if (init_st == 0) begin
         chk(c == CMD_PRE && a[10], "R2 first command all-bank precharge", int'(c), int'(CMD_PRE));
         for (int i = 0; i < 4; i++) l_pre[i] = cyc;
         init_st = 1;
      end else if (init_st == 1) begin
         chk(c == CMD_MRS && a == MODE, "R2 mode load value", a, MODE);
         chk(cyc - l_pre[0] >= T_RP, "R2 mode load after precharge", cyc - l_pre[0], T_RP);
         l_mrs = cyc;
         init_st = 2;
      end else begin
         if (exp_ref) chk(c == CMD_REF, "R11 command between precharge-all and refresh", int'(c), int'(CMD_REF));
         if (c != CMD_READ && c != CMD_WRITE) begin
            if (col_strobe) chk(1'b0, "R1 strobe on non-column command", 1, 0);
            if (acc_now)    chk(1'b0, "R8 accept not followed by column", int'(c), int'(CMD_READ));
         end
         case (c)
            CMD_ACT: begin
               chk(!m_open[b] && b == pb, "R9 activate target", b, pb);
               chk(a == prow, "R10 activate row", a, prow);
               chk(cyc - l_pre[b] >= T_RP, "R5 precharge to activate", cyc - l_pre[b], T_RP);
               chk(cyc - l_act[b] >= T_RC, "R5 activate to activate same bank", cyc - l_act[b], T_RC);
               chk(cyc - l_ref >= T_RC, "R5 refresh to activate", cyc - l_ref, T_RC);
               chk(cyc - l_any_act >= T_RRD, "R7 activate to activate any bank", cyc - l_any_act, T_RRD);
               chk(cyc - l_mrs >= T_MRD, "R7 mode load to activate", cyc - l_mrs, T_MRD);
               m_open[b] = 1'b1; m_row[b] = a; l_act[b] = cyc; l_any_act = cyc;
            end
            CMD_READ, CMD_WRITE: begin
               chk(acc_now, "R8 column command without accept", 0, 1);
               chk(b == ab, "R3 column bank", b, ab);
               chk(m_open[b] && m_row[b] == arow, "R8 column on open row", m_row[b], arow);
               chk(cyc - l_act[b] >= T_RCD, "R4 activate to column", cyc - l_act[b], T_RCD);
               chk(a == exp_col_addr(acol), "R10 column address", a, exp_col_addr(acol));
               chk(col_strobe && col_write == awr && ((c == CMD_WRITE) == awr), "R1 column kind", int'(c), awr ? 4 : 5);
               if (c == CMD_WRITE) l_wr[b] = cyc;
            end
            CMD_PRE: begin
               if (a[10]) begin
                  for (int i = 0; i < 4; i++) begin
                     if (m_open[i]) begin
                        chk(cyc - l_act[i] >= T_RAS, "R6 activate to precharge-all", cyc - l_act[i], T_RAS);
                        chk(cyc - l_wr[i] >= T_WR, "R6 write to precharge-all", cyc - l_wr[i], T_WR);
                     end
                     m_open[i] = 1'b0; l_pre[i] = cyc;
                  end
                  exp_ref = 1'b1;
               end else begin
                  chk(m_open[b] && b == pb && m_row[b] != prow, "R9 precharge only on row miss", b, pb);
                  chk(cyc - l_act[b] >= T_RAS, "R6 activate to precharge", cyc - l_act[b], T_RAS);
                  chk(cyc - l_wr[b] >= T_WR, "R6 write to precharge", cyc - l_wr[b], T_WR);
                  m_open[b] = 1'b0; l_pre[b] = cyc;
               end
            end
            CMD_REF: begin
               for (int i = 0; i < 4; i++) begin
                  chk(!m_open[i], "R11 refresh with bank open", i, -1);
                  chk(cyc - l_pre[i] >= T_RP, "R11 precharge to refresh", cyc - l_pre[i], T_RP);
               end
               chk(cyc - l_ref_int >= T_REFI - SLACK && cyc - l_ref_int <= T_REFI + SLACK,
                   "R11 refresh interval", cyc - l_ref_int, T_REFI);
               l_ref = cyc; l_ref_int = cyc; n_ref++; exp_ref = 1'b0;
            end
            default: chk(1'b0, "R1 unexpected command code", int'(c), int'(CMD_DESL));
         endcase
      end
   end

   task automatic do_req(input int b, input int row, input int col, input bit wr);
      int w;
      @(negedge clk);
      pb = b; prow = row; pwr = wr;
      req_bank = BANK_W'(b); req_row = ROW_W'(row); req_col = COL_W'(col); req_write = wr;
      req_valid = 1'b1;
      w = 0;
      #1;
      while (!req_ready) begin
         @(negedge clk);
         #1;
         w++;
         if (w > 300) begin
            chk(1'b0, "R8 request never accepted", w, 300);
            break;
         end
      end
      @(posedge clk);
      #1 req_valid = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      chk(1'b0, "R8 watchdog expired", cyc, 200000);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      for (int i = 0; i < 4; i++) begin
         l_act[i] = -1000; l_pre[i] = -1000; l_wr[i] = -1000; m_row[i] = 0; m_open[i] = 1'b0;
      end
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      l_ref_int = cyc;
      // Sweep per bank: rows alternate between hit and miss, reads and writes, one column with bit 10 set
      for (int b = 0; b < 4; b++) begin
         for (int k = 0; k < 8; k++) begin
            do_req(b, (((k >> 1) & 1) != 0) ? 'h155 : 3 + b, (k == 7) ? 'h4A5 : b * 16 + k, k[0]);
         end
      end
      // Interleaved banks with rotating rows
      for (int i = 0; i < 24; i++) do_req(i % 4, 20 + (i % 3), i, i[0]);
      // Row hits on one bank, back-to-back column traffic
      for (int i = 0; i < 8; i++) do_req(2, 21, 'h7F0 + i, i[1]);
      // Highest row and column values
      do_req(3, (1 << ROW_W) - 1, (1 << COL_W) - 1, 1'b1);
      do_req(3, (1 << ROW_W) - 1, 0, 1'b0);
      // Idle: refresh continues on its own
      repeat (3 * T_REFI) @(negedge clk);
      chk(n_ref >= (cyc / T_REFI) - 1, "R11 refresh count", n_ref, (cyc / T_REFI) - 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule